// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt inputs and drives one request line toward a processor. Software programs, per source, a trigger kind, a 3-bit priority and a vector word, then opens sources through an enable command and closes them through a disable command. When the request line is high, the handler reads the vector port. That read returns the vector of the winning source, acknowledges the source, and records the source on an eight-level nesting stack. While a source sits on top of that stack, only a source of strictly higher priority can raise the request line again.

A write of any value to the end-of-interrupt port removes the top stack entry and restores the previous priority threshold. If the vector port is read when no source beats the current threshold, it returns a programmable spurious word. A status port reports the number of the source now being serviced. Raw inputs pass through a two-stage synchroniser before edge detection. Inputs listed in a parameter as external may also use active-low level and falling-edge triggers.

Top module: `vic_top`

## Requirements
- R1: A write to the enable port (address 0x43) sets each mask bit n whose data bit n is 1. A write to the disable port (0x44) clears each such bit. Data bits of 0 leave the mask unchanged. The mask reads back at 0x42.
- R2: The mode word of source n is at address n. Bits [2:0] hold the priority, where 7 is the most urgent. Bits [5:4] hold the trigger: 0 is active-high level, 1 is rising edge, 2 is active-low level, 3 is falling edge. The vector word of source n is at address 0x20+n.
- R3: For a source that is not marked external, bit 5 of the mode word is forced to 0. A write of level-low therefore reads back and acts as level-high.
- R4: A read at 0x40 returns the vector of the pending, enabled source with the highest priority. Among equal priorities, the lowest source number wins.
- R5: When no pending, enabled source beats the current threshold, a read at 0x40 returns the spurious word (read/write at 0x47) and pushes nothing. With an empty stack, the status port at 0x41 reads 0.
- R6: A read at 0x40 that finds a winner pushes that source onto the nesting stack. Afterwards the status port returns its source number.
- R7: The request line is high exactly when some pending, enabled source has a priority strictly above the priority on top of the stack, or above none if the stack is empty.
- R8: A write of any value to 0x46 pops one stack entry. A write there with an empty stack has no effect. Eight such writes always empty the stack.
- R9: An edge-triggered source latches its pending bit after the synchroniser. The latch is cleared when its vector is read, or when the clear port (0x45) is written with a 1 in that source's bit.
- R10: A level-triggered source is pending while its input is at the active level. A source whose mask bit is 0 never wins and never raises the request.
- R11: After reset, all mask bits are 0, every mode word is 0, the stack is empty, the request is low and the spurious word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Raw interrupt inputs, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (the vector port has a side effect) |
| addr | input | 7 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Each source is given a priority in a different position of a cyclic pattern. Table-driven input patterns then tell apart the following cases:
- a lone source;
- two sources of different priority;
- two sources that tie, which separates lowest-number selection from highest-number selection;
- a pattern whose winner lies at the high end of the index;
- an empty pattern that must give the spurious word.

Directed sequences cover the remaining cases:
- an eight-deep ascending chain, to check the strict-greater threshold and full unwinding;
- a masked source that outranks the winner;
- a falling-edge external source, cleared once by acknowledgement and once by the clear port;
- an internal source programmed as level-low.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int PRIO_W = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    // bit 0: edge sensitive, bit 1: active-low polarity
    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_RISE   = 2'd1,
        TRIG_LVL_LO = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_e;

    typedef struct packed {
        trig_e trig;
        prio_t prio;
    } mode_t;

    localparam logic [ADDR_W-1:0] A_MODE_BASE = 7'h00;
    localparam logic [ADDR_W-1:0] A_VEC_BASE  = 7'h20;
    localparam logic [ADDR_W-1:0] A_IVR       = 7'h40;
    localparam logic [ADDR_W-1:0] A_STAT      = 7'h41;
    localparam logic [ADDR_W-1:0] A_MASK      = 7'h42;
    localparam logic [ADDR_W-1:0] A_EN        = 7'h43;
    localparam logic [ADDR_W-1:0] A_DIS       = 7'h44;
    localparam logic [ADDR_W-1:0] A_CLR       = 7'h45;
    localparam logic [ADDR_W-1:0] A_EOI       = 7'h46;
    localparam logic [ADDR_W-1:0] A_SPU       = 7'h47;

    // internal sources cannot use the low/falling polarity
    function automatic trig_e legal_trig(input logic [1:0] t, input logic ext);
        return trig_e'(ext ? t : {1'b0, t[0]});
    endfunction

    function automatic mode_t word_to_mode(input logic [DATA_W-1:0] w, input logic ext);
        mode_t m;
        m.trig = legal_trig(w[5:4], ext);
        m.prio = w[PRIO_W-1:0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] mode_to_word(input mode_t m);
        return {26'd0, m.trig, 1'b0, m.prio};
    endfunction

endpackage

// File: rtl/vic_source.sv
module vic_source
    import vic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  raw,
    input  trig_e trig,
    input  logic  ack,
    input  logic  clr,
    output logic  pend
);
    logic sync1, sync2, prev, latch;
    logic act_now, act_prev, edge_hit;

    assign act_now  = sync2 ^ trig[1];
    assign act_prev = prev ^ trig[1];
    assign edge_hit = trig[0] && act_now && !act_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
            latch <= 1'b0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            prev  <= sync2;
            if (clr || ack)
                latch <= 1'b0;
            else if (edge_hit)
                latch <= 1'b1;
        end
    end

    assign pend = trig[0] ? latch : act_now;

    // R9: a clear or acknowledge empties the edge latch
    a_r9_latch_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr || ack) |=> !latch);

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int ID_W = 5
)(
    input  logic [NSRC-1:0] req,
    input  prio_t           prio [NSRC],
    output logic            valid,
    output logic [ID_W-1:0] id,
    output prio_t           best
);
    // strict compare keeps the lowest index on ties
    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (req[n] && (!valid || prio[n] > best)) begin
                valid = 1'b1;
                id    = ID_W'(n);
                best  = prio[n];
            end
        end
    end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack
    import vic_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 5
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [ID_W-1:0] push_id,
    input  prio_t           push_prio,
    output logic            empty,
    output logic            full,
    output logic [ID_W-1:0] top_id,
    output prio_t           top_prio
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ID_W-1:0] id_q   [DEPTH];
    prio_t           prio_q [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [IX_W-1:0]  top_ix;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign top_ix   = IX_W'(cnt - 1'b1);
    assign top_id   = id_q[top_ix];
    assign top_prio = prio_q[top_ix];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                id_q[k]   <= '0;
                prio_q[k] <= '0;
            end
        end else if (push && !full) begin
            id_q[IX_W'(cnt)]   <= push_id;
            prio_q[IX_W'(cnt)] <= push_prio;
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    a_r8_depth_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));
    a_r8_single_op: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    // R7: each nested entry outranks the one beneath it
    a_r7_nest_rises: assert property (@(posedge clk) disable iff (rst)
        (push && !empty) |=> top_prio > $past(top_prio));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int               NSRC     = 32,
    parameter int               VEC_W    = 32,
    parameter int               DEPTH    = 8,
    parameter logic [NSRC-1:0]  EXT_MASK = 32'hF000_0000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [6:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_out
);
    localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    mode_t            mode_q [NSRC];
    logic [VEC_W-1:0] vec_q  [NSRC];
    prio_t            prio_v [NSRC];
    logic [NSRC-1:0]  mask_q, pend, ack, clr;
    logic [VEC_W-1:0] spu_q;
    logic [31:0]      rdata_q, rd_mux;

    logic             win_valid, grant, ivr_rd, push, pop;
    logic [ID_W-1:0]  win_id, top_id;
    prio_t            win_prio, top_prio;
    logic             stk_empty, stk_full;
    logic [ID_W-1:0]  aidx;

    assign aidx   = addr[ID_W-1:0];
    assign ivr_rd = rd_en && (addr == A_IVR);
    assign grant  = win_valid && (stk_empty || win_prio > top_prio);
    assign push   = ivr_rd && grant;
    assign pop    = wr_en && (addr == A_EOI) && !stk_empty;
    assign clr    = (wr_en && addr == A_CLR) ? wdata[NSRC-1:0] : '0;
    assign irq_out = grant;
    assign rdata   = rdata_q;

    // per-source configuration and pending logic
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[i] <= '0;
                vec_q[i]  <= '0;
            end else if (wr_en && addr == ADDR_W'(int'(A_MODE_BASE) + i)) begin
                mode_q[i] <= word_to_mode(wdata, EXT_MASK[i]);
            end else if (wr_en && addr == ADDR_W'(int'(A_VEC_BASE) + i)) begin
                vec_q[i] <= wdata[VEC_W-1:0];
            end
        end

        assign prio_v[i] = mode_q[i].prio;
        assign ack[i]    = push && (win_id == ID_W'(i));

        vic_source u_src (
            .clk  (clk),
            .rst  (rst),
            .raw  (src_in[i]),
            .trig (mode_q[i].trig),
            .ack  (ack[i]),
            .clr  (clr[i]),
            .pend (pend[i])
        );

        if (!EXT_MASK[i]) begin : g_int
            // R3: internal sources never hold the low/falling polarity
            a_r3_internal_polarity: assert property (@(posedge clk) disable iff (rst)
                !mode_q[i].trig[1]);
        end
    end

    vic_arbiter #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
        .req   (pend & mask_q),
        .prio  (prio_v),
        .valid (win_valid),
        .id    (win_id),
        .best  (win_prio)
    );

    vic_nest_stack #(.DEPTH(DEPTH), .ID_W(ID_W)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_id   (win_id),
        .push_prio (win_prio),
        .empty     (stk_empty),
        .full      (stk_full),
        .top_id    (top_id),
        .top_prio  (top_prio)
    );

    // mask and spurious word
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            spu_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_EN)
                mask_q <= mask_q | wdata[NSRC-1:0];
            else if (addr == A_DIS)
                mask_q <= mask_q & ~wdata[NSRC-1:0];
            else if (addr == A_SPU)
                spu_q <= wdata[VEC_W-1:0];
        end
    end

    // read mux, registered on the strobe
    always_comb begin
        rd_mux = '0;
        if (addr < A_VEC_BASE) begin
            if (int'(addr) < NSRC)
                rd_mux = mode_to_word(mode_q[aidx]);
        end else if (addr < A_IVR) begin
            if (int'(addr) - int'(A_VEC_BASE) < NSRC)
                rd_mux = 32'(vec_q[aidx]);
        end else if (addr == A_IVR) begin
            rd_mux = grant ? 32'(vec_q[win_id]) : 32'(spu_q);
        end else if (addr == A_STAT) begin
            rd_mux = stk_empty ? 32'd0 : 32'(top_id);
        end else if (addr == A_MASK) begin
            rd_mux = 32'(mask_q);
        end else if (addr == A_SPU) begin
            rd_mux = 32'(spu_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    a_r1_enable_sets: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_EN) |=>
            ((mask_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
    a_r1_disable_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DIS) |=> ((mask_q & $past(wdata[NSRC-1:0])) == '0));
    a_r5_spurious_word: assert property (@(posedge clk) disable iff (rst)
        (ivr_rd && !grant) |=> (rdata == 32'($past(spu_q))));
    a_r10_masked_never_wins: assert property (@(posedge clk) disable iff (rst)
        push |-> mask_q[win_id]);

endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] SPU = 32'h0000_DEAD;

    // {src pattern, expected vector}; source n has priority (3n mod 8)
    localparam logic [63:0] TBL [7] = '{
        {32'h0000_0001, 32'h0000_0100},
        {32'h0000_0003, 32'h0000_0101},
        {32'h0000_0024, 32'h0000_0105},
        {32'h0000_2020, 32'h0000_0105},
        {32'h8000_0100, 32'h0000_011F},
        {32'h0000_0000, SPU},
        {32'h4000_0400, 32'h0000_010A}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_out;

    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_top dut (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic int prio_of(input int n);
        return (n * 3) % 8;
    endfunction

    initial begin
        logic [31:0] d;
        int chain [8] = '{0, 3, 6, 1, 4, 7, 2, 5};

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check({31'd0, irq_out}, 32'd0, "R11 irq low");
        bus_rd(7'h42, d); check(d, 32'd0, "R11 mask");
        bus_rd(7'h05, d); check(d, 32'd0, "R11 mode");
        bus_rd(7'h41, d); check(d, 32'd0, "R11 status");
        bus_rd(7'h40, d); check(d, 32'd0, "R11 spurious word");

        // configuration, R2 layout
        for (int n = 0; n < 32; n++) begin
            bus_wr(7'(n), 32'(prio_of(n)));
            bus_wr(7'(32 + n), 32'h100 + 32'(n));
        end
        bus_wr(7'h47, SPU);
        bus_rd(7'h0D, d); check(d, 32'h7, "R2 mode readback");
        bus_rd(7'h3F, d); check(d, 32'h11F, "R2 vector readback");

        // R1 enable/disable/zero bits
        bus_wr(7'h43, 32'h0000_00F0);
        bus_wr(7'h44, 32'h0000_0030);
        bus_rd(7'h42, d); check(d, 32'h0000_00C0, "R1 set then clear");
        bus_wr(7'h43, 32'h0);
        bus_wr(7'h44, 32'h0);
        bus_rd(7'h42, d); check(d, 32'h0000_00C0, "R1 zero bits no effect");
        bus_wr(7'h43, 32'hFFFF_FFFF);

        // R4/R5/R7 table
        foreach (TBL[k]) begin
            src_in = TBL[k][63:32];
            settle();
            check({31'd0, irq_out}, {31'd0, TBL[k][63:32] != 0}, "R7 request");
            bus_rd(7'h40, d); check(d, TBL[k][31:0], "R4 vector select");
            if (TBL[k][31:0] != SPU) bus_wr(7'h46, 32'h0);
            else begin bus_rd(7'h41, d); check(d, 32'd0, "R5 status idle"); end
            src_in = '0;
            settle();
        end

        // R10 masked source ignored
        bus_wr(7'h44, 32'h0000_0020);
        src_in = 32'h0000_0024;
        settle();
        bus_rd(7'h40, d); check(d, 32'h102, "R10 masked ignored");
        bus_wr(7'h46, 32'h0);
        src_in = '0;
        bus_wr(7'h43, 32'h0000_0020);
        settle();

        // R6/R7/R8 nesting
        src_in = 32'h0000_0008;
        settle();
        bus_rd(7'h40, d); check(d, 32'h103, "R6 first vector");
        bus_rd(7'h41, d); check(d, 32'd3, "R6 status top");
        check({31'd0, irq_out}, 32'd0, "R7 no equal preempt");
        src_in[31] = 1'b1; settle();
        check({31'd0, irq_out}, 32'd1, "R7 higher preempts");
        bus_rd(7'h40, d); check(d, 32'h11F, "R6 nested vector");
        bus_rd(7'h41, d); check(d, 32'd31, "R6 nested status");
        src_in[12] = 1'b1; settle();
        check({31'd0, irq_out}, 32'd0, "R7 lower blocked");
        bus_wr(7'h46, 32'h0);
        bus_rd(7'h41, d); check(d, 32'd3, "R8 pop restores");
        check({31'd0, irq_out}, 32'd1, "R7 threshold restored");
        bus_wr(7'h46, 32'h0);
        bus_rd(7'h41, d); check(d, 32'd0, "R8 empty status");
        src_in = '0; settle();

        // R8 eight-deep chain
        foreach (chain[k]) begin
            src_in[chain[k]] = 1'b1;
            settle();
            bus_rd(7'h40, d); check(d, 32'h100 + 32'(chain[k]), "R8 chain push");
        end
        bus_rd(7'h41, d); check(d, 32'd5, "R8 full status");
        check({31'd0, irq_out}, 32'd0, "R7 none above top");
        bus_rd(7'h40, d); check(d, SPU, "R5 spurious when blocked");
        for (int k = 0; k < 8; k++) bus_wr(7'h46, 32'h0);
        bus_rd(7'h41, d); check(d, 32'd0, "R8 eight pops idle");
        check({31'd0, irq_out}, 32'd1, "R8 request after unwind");
        bus_wr(7'h46, 32'h0);
        bus_rd(7'h40, d); check(d, 32'h105, "R8 extra pop ignored");
        bus_wr(7'h46, 32'h0);
        src_in = '0; settle();

        // R3 internal source level-low behaves as level-high
        bus_wr(7'h04, 32'h24);
        bus_rd(7'h04, d); check(d, 32'h04, "R3 readback forced");
        settle();
        check({31'd0, irq_out}, 32'd0, "R3 low input idle");
        src_in[4] = 1'b1; settle();
        bus_rd(7'h40, d); check(d, 32'h104, "R3 acts level-high");
        bus_wr(7'h46, 32'h0);
        src_in = '0; settle();

        // R2 external level-low honoured
        bus_wr(7'h1D, 32'h25);
        bus_rd(7'h1D, d); check(d, 32'h25, "R2 external level-low kept");
        settle();
        bus_rd(7'h40, d); check(d, 32'h11D, "R2 level-low active");
        bus_wr(7'h46, 32'h0);
        bus_wr(7'h1D, 32'h05);
        settle();

        // R9 falling edge on external source 28
        bus_wr(7'h1C, 32'h36);
        src_in[28] = 1'b1; settle();
        check({31'd0, irq_out}, 32'd0, "R9 rising ignored");
        src_in[28] = 1'b0; settle();
        check({31'd0, irq_out}, 32'd1, "R9 falling latched");
        bus_rd(7'h40, d); check(d, 32'h11C, "R9 edge vector");
        bus_wr(7'h46, 32'h0);
        check({31'd0, irq_out}, 32'd0, "R9 auto clear on read");
        src_in[28] = 1'b1; settle();
        src_in[28] = 1'b0; settle();
        check({31'd0, irq_out}, 32'd1, "R9 second edge");
        bus_wr(7'h45, 32'h1000_0000);
        check({31'd0, irq_out}, 32'd0, "R9 clear port");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule